// File: doc/BRIEF.md
# Windowed Service Watchdog

This block watches software through a service window. It counts ticks of an idle-timer clock enable from the last accepted service. Software must write a keyed 8-bit service word after the lower limit of the window and before the upper limit. A service that comes too soon, a service that never comes, or a malformed write raises an error. On an error the active-low fault output goes low and stays low for a fixed number of ticks. The last error cause is also presented on a small output.

The service word holds three fields: a window select, a fixed key and a clock-monitor enable. The first write after reset that carries the right key fixes the window select and the clock-monitor enable for good. From then on, every write must repeat the fixed word bit for bit. A sideband boot-entry pulse acts as a forced service. It restarts the window and is never judged as early.

The service write is a one-cycle strobe with its data. Every write is taken in the cycle it is presented, so there is no back-pressure and no ready signal. Tick, boot pulse, fault and cause are plain level pins. Reset is synchronous and active high.

Top module: `wdog_window`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `fault_n` is 1, `err_cause` is 0, `cmon_en` is 1, the window select is 2'b11, the configuration is unlocked and the elapsed count is 0.
- R2: A service word carries the window select in bits [7:6], the key in bits [5:1] and the clock-monitor enable in bit 0. The key is accepted only when it equals the parameter KEY (default 5'b01100).
- R3: The first write after reset whose key matches locks bits [7:6] and bit 0. From the next cycle on, `cmon_en` equals the locked bit 0. The write also counts as a service.
- R4: A write with a wrong key while unlocked is a bad-write error. The block stays unlocked, and `cmon_en` and the window keep their reset values.
- R5: Once locked, a write whose 8 bits differ in any way from the locked word is a bad-write error. The locked window and clock-monitor enable do not change.
- R6: An accepted service that arrives when fewer than LOW_TICKS (default 2048) ticks have elapsed since the last restart is an early error (cause 1).
- R7: When the elapsed count reaches the upper limit UPPER_BASE << window (default 8192, 16384, 32768 or 65536 for window 0 to 3) without a service, a late error (cause 2) is raised.
- R8: The elapsed count advances only in cycles with `tick` high. It clears on every accepted service, on every forced service and on every error.
- R9: A `boot_svc` pulse restarts the elapsed count and never causes an early error, whatever the count.
- R10: In the cycle after an error, `fault_n` goes low. It stays low until STRETCH ticks (16 to 32, default 16) have passed. A new error reloads the full stretch.
- R11: `err_cause` holds the code of the latest error until the next error or reset: 0 none, 1 early, 2 late, 3 bad write. When errors coincide in one cycle, bad write beats late and late beats early.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Idle-timer tick enable, one tick per high cycle |
| wr_en | input | 1 | Service write strobe, one cycle per write |
| wr_data | input | 8 | Service word |
| boot_svc | input | 1 | Forced service on boot-routine entry |
| fault_n | output | 1 | Fault output, low while an error is being stretched |
| err_cause | output | 2 | Cause of the latest error |
| cmon_en | output | 1 | Clock-monitor enable from the configuration |

## Verification
The hardest state to reach is a locked configuration that is then challenged. This needs a write with the correct key but a different window select, followed by a long idle stretch. Only the timing of the next late error shows that the window did not change. The bench reaches this with a directed sequence. It locks window 0, sends the altered word, then idles past the short limit and expects a late error at the old limit. The bench runs with reduced window parameters so that early, in-window and late services all occur often. Random writes, corrupted words, boot pulses and tick gaps then run against a cycle model of the requirements, and this traffic also produces coinciding errors that test the priority rule.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_EARLY = 2'd1,
    CAUSE_LATE  = 2'd2,
    CAUSE_BAD   = 2'd3
  } wd_cause_e;

  typedef struct packed {
    logic [1:0] win;
    logic [4:0] key;
    logic       cmon;
  } svc_word_t;

  localparam logic [1:0] WIN_AT_RESET  = 2'b11;
  localparam logic       CMON_AT_RESET = 1'b1;

endpackage

// File: rtl/wdog_cfg.sv
module wdog_cfg
  import wdog_pkg::*;
#(
  parameter logic [4:0] KEY = 5'b01100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [1:0] win,
  output logic       cmon,
  output logic       svc_ok,
  output logic       wr_bad
);

  svc_word_t word_in;
  svc_word_t word_q;
  logic      locked;
  logic      key_hit;
  logic      word_hit;

  assign word_in  = svc_word_t'(wr_data);
  assign key_hit  = (word_in.key == KEY);
  assign word_hit = (word_in == word_q);

  // Unlocked writes are judged on the key alone; locked writes on all bits.
  always_comb begin
    svc_ok = 1'b0;
    wr_bad = 1'b0;
    if (wr_en) begin
      if (!locked) begin
        svc_ok = key_hit;
        wr_bad = !key_hit;
      end else begin
        svc_ok = word_hit;
        wr_bad = !word_hit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      word_q <= '{win: WIN_AT_RESET, key: KEY, cmon: CMON_AT_RESET};
    end else if (wr_en && !locked && key_hit) begin
      locked <= 1'b1;
      word_q <= word_in;
    end
  end

  assign win  = word_q.win;
  assign cmon = word_q.cmon;

  // R3
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> locked);

  // R5
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(word_q));

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int LOW_TICKS  = 2048,
  parameter int UPPER_BASE = 8192
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic [1:0] win,
  input  logic       svc_ok,
  input  logic       wr_bad,
  input  logic       boot_svc,
  output logic       err_hit,
  output wd_cause_e  err_kind
);

  localparam int CNT_W = $clog2(UPPER_BASE * 8) + 1;
  localparam logic [CNT_W-1:0] LOW_C  = CNT_W'(LOW_TICKS);
  localparam logic [CNT_W-1:0] BASE_C = CNT_W'(UPPER_BASE);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] upper;
  logic             at_upper;
  logic             too_soon;
  logic             restart;

  assign upper    = BASE_C << win;
  assign at_upper = (cnt >= upper);
  assign too_soon = svc_ok && !boot_svc && (cnt < LOW_C);

  // Bad write outranks late, late outranks early.
  always_comb begin
    err_kind = CAUSE_NONE;
    if (wr_bad)        err_kind = CAUSE_BAD;
    else if (at_upper) err_kind = CAUSE_LATE;
    else if (too_soon) err_kind = CAUSE_EARLY;
  end

  assign err_hit = (err_kind != CAUSE_NONE);
  assign restart = err_hit || svc_ok || boot_svc;

  always_ff @(posedge clk) begin
    if (rst)          cnt <= '0;
    else if (restart) cnt <= '0;
    else if (tick)    cnt <= cnt + 1'b1;
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= upper);

  // R9
  boot_clear_chk: assert property (@(posedge clk) disable iff (rst)
    boot_svc |=> (cnt == '0));

endmodule

// File: rtl/wdog_fault.sv
module wdog_fault
  import wdog_pkg::*;
#(
  parameter int STRETCH = 16
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      err_hit,
  input  wd_cause_e err_kind,
  output logic      fault_n,
  output wd_cause_e cause_q
);

  localparam int HOLD_W = $clog2(STRETCH + 1);

  logic [HOLD_W-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold    <= '0;
      cause_q <= CAUSE_NONE;
    end else if (err_hit) begin
      hold    <= HOLD_W'(STRETCH);
      cause_q <= err_kind;
    end else if (tick && hold != '0) begin
      hold    <= hold - 1'b1;
    end
  end

  assign fault_n = (hold == '0);

  // R10
  fault_on_err_chk: assert property (@(posedge clk) disable iff (rst)
    err_hit |=> !fault_n);

  // R10
  quiet_high_chk: assert property (@(posedge clk) disable iff (rst)
    (fault_n && !err_hit) |=> fault_n);

  // R11
  cause_kept_chk: assert property (@(posedge clk) disable iff (rst)
    !err_hit |=> $stable(cause_q));

endmodule

// File: rtl/wdog_window.sv
module wdog_window
  import wdog_pkg::*;
#(
  parameter int         LOW_TICKS  = 2048,
  parameter int         UPPER_BASE = 8192,
  parameter int         STRETCH    = 16,
  parameter logic [4:0] KEY        = 5'b01100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       boot_svc,
  output logic       fault_n,
  output logic [1:0] err_cause,
  output logic       cmon_en
);

  logic [1:0] win;
  logic       svc_ok;
  logic       wr_bad;
  logic       err_hit;
  wd_cause_e  err_kind;
  wd_cause_e  cause_q;

  wdog_cfg #(.KEY(KEY)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .win     (win),
    .cmon    (cmon_en),
    .svc_ok  (svc_ok),
    .wr_bad  (wr_bad)
  );

  wdog_timer #(.LOW_TICKS(LOW_TICKS), .UPPER_BASE(UPPER_BASE)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .win      (win),
    .svc_ok   (svc_ok),
    .wr_bad   (wr_bad),
    .boot_svc (boot_svc),
    .err_hit  (err_hit),
    .err_kind (err_kind)
  );

  wdog_fault #(.STRETCH(STRETCH)) u_fault (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .err_hit  (err_hit),
    .err_kind (err_kind),
    .fault_n  (fault_n),
    .cause_q  (cause_q)
  );

  assign err_cause = cause_q;

endmodule

// File: tb/wdog_window_bench.sv
module wdog_window_bench;

  localparam int         LOW  = 64;
  localparam int         BASE = 256;
  localparam int         STR  = 20;
  localparam logic [4:0] KEYV = 5'b01100;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       wr_en = 1'b0;
  logic       boot_svc = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       fault_n;
  logic [1:0] err_cause;
  logic       cmon_en;

  int nchk = 0;
  int nfail = 0;

  always #2.5 clk = ~clk;

  wdog_window #(.LOW_TICKS(LOW), .UPPER_BASE(BASE), .STRETCH(STR), .KEY(KEYV)) u_wdog_window (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .boot_svc(boot_svc), .fault_n(fault_n), .err_cause(err_cause), .cmon_en(cmon_en)
  );

  // Cycle model written from the requirements.
  logic       m_lock;
  logic [7:0] m_word;
  int         m_cnt, m_hold, m_cause;
  int         me;
  bit         msvc;

  function automatic int win_limit(logic [7:0] w);
    return BASE << w[7:6];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_lock <= 1'b0; m_word <= {2'b11, KEYV, 1'b1};
      m_cnt <= 0; m_hold <= 0; m_cause <= 0;
    end else begin
      me = 0; msvc = 1'b0;
      if (wr_en) begin
        if (!m_lock) begin
          if (wr_data[5:1] == KEYV) begin msvc = 1'b1; m_lock <= 1'b1; m_word <= wr_data; end
          else me = 3;
        end else if (wr_data == m_word) msvc = 1'b1;
        else me = 3;
      end
      if (me == 0 && m_cnt >= win_limit(m_word)) me = 2;
      else if (me == 0 && msvc && !boot_svc && m_cnt < LOW) me = 1;
      if (me != 0 || msvc || boot_svc) m_cnt <= 0;
      else if (tick) m_cnt <= m_cnt + 1;
      if (me != 0) begin m_hold <= STR; m_cause <= me; end
      else if (tick && m_hold > 0) m_hold <= m_hold - 1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(bit t, bit w, logic [7:0] d, bit b);
    @(negedge clk);
    chk("R10 fault_n vs model", int'(fault_n), (m_hold == 0) ? 1 : 0);
    chk("R11 err_cause vs model", int'(err_cause), m_cause);
    chk("R3 cmon_en vs model", int'(cmon_en), int'(m_word[0]));
    tick = t; wr_en = w; wr_data = d; boot_svc = b;
  endtask

  task automatic idle(int n);
    repeat (n) step(1'b1, 1'b0, 8'h00, 1'b0);
  endtask

  task automatic wr(logic [7:0] d);
    step(1'b1, 1'b1, d, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; tick = 1'b0; wr_en = 1'b0; boot_svc = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(150000 * 5);
    nchk++; nfail++;
    $display("FAIL R10 watchdog expired: got 1 expected 0");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    int lows;
    logic [7:0] good;
    void'($urandom(32'd20240611));
    do_reset();
    idle(1);
    chk("R1 fault_n after reset", int'(fault_n), 1);
    chk("R1 err_cause after reset", int'(err_cause), 0);
    chk("R1 cmon_en after reset", int'(cmon_en), 1);

    // Unlocked window 11: late at BASE*8 ticks, then a full stretch.
    lows = 0;
    for (int i = 0; i < 2140; i++) begin
      idle(1);
      if (!fault_n) lows++;
    end
    chk("R7 late at reset window", int'(err_cause), 2);
    chk("R10 stretch length", lows, STR);

    wr(8'h00); idle(100);
    chk("R4 wrong key is bad write", int'(err_cause), 3);
    chk("R4 still unlocked cmon", int'(cmon_en), 1);

    wr(8'h18); idle(5);  // window 00, key 01100, cmon 0
    chk("R2 key field accepted, cmon bit 0", int'(cmon_en), 0);
    chk("R3 lock service raises nothing", int'(err_cause), 3);
    chk("R3 fault high after lock", int'(fault_n), 1);

    idle(100); wr(8'h58); idle(5);  // keyed but window 01
    chk("R5 mismatch is bad write", int'(err_cause), 3);
    chk("R5 cmon unchanged", int'(cmon_en), 0);
    idle(300);
    chk("R5 window still 00: late at BASE", int'(err_cause), 2);

    wr(8'h18); idle(3);
    chk("R6 early service", int'(err_cause), 1);

    idle(200); step(1'b1, 1'b0, 8'h00, 1'b1); idle(100); wr(8'h18); idle(3);
    chk("R8 boot restarted count", int'(err_cause), 1);
    chk("R9 no error after boot", int'(fault_n), 1);

    idle(10); step(1'b1, 1'b0, 8'h00, 1'b1); idle(3);
    chk("R9 early boot not an error", int'(err_cause), 1);

    repeat (1000) step(1'b0, 1'b0, 8'h00, 1'b0);
    chk("R8 no count without tick", int'(fault_n), 1);
    idle(100); wr(8'h18); idle(3);
    chk("R8 in-window after tick gap", int'(err_cause), 1);
    chk("R8 fault high after tick gap", int'(fault_n), 1);

    // Random phase against the model.
    do_reset();
    good = {2'($urandom_range(0, 3)), KEYV, 1'($urandom_range(0, 1))};
    for (int i = 0; i < 60000; i++) begin
      int r;
      logic [7:0] d;
      r = int'($urandom % 1000);
      d = (($urandom % 5) == 0) ? 8'($urandom) : good;
      if (i % 20000 == 19999) begin
        do_reset();
        good = {2'($urandom_range(0, 3)), KEYV, 1'($urandom_range(0, 1))};
      end
      step(($urandom % 4) != 0, r < 3, d, r == 999);
    end
    idle(2);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

endmodule